// File: doc/BRIEF.md
# Edge-Latched Interrupt Controller

This block gathers eleven peripheral request lines into one interrupt request for a processor. Every clock it compares each line with the value it held one clock earlier. A low-to-high change on a line sets that source's pending bit. A line that simply stays high does nothing more. Pending bits stay set until software clears them.

Software uses a single-cycle 32-bit register port. It reads the pending bits and the enable bits there. It clears pending bits by writing zeros, and it picks the enabled sources by writing the enable register. The output to the CPU is a level. It is high whenever some pending bit has its enable bit set, so the CPU sees it drop as soon as the last enabled pending source is cleared.

Top module: `irq_latch_ctrl`

## Requirements
- R1: While reset is applied, and until the first write after it, both registers read as zero and `cpu_irq` is low. Reset also clears the stored previous line values.
- R2: A rising edge on `irq_line[i]` sets pending bit i. The bit reads back as set from the cycle after the edge onward.
- R3: A line that stays high, or stays low, never sets its pending bit. After an acknowledge, the bit is set again only after the line falls and then rises once more.
- R4: A write to offset 0x00 gives the pending register the value old AND written data, on bits 0 to 10. A written 0 clears a bit and a written 1 keeps it.
- R5: A write to offset 0x04 loads the enable register with written data bits 0 to 10. Without such a write, the enable register does not change.
- R6: `cpu_irq` is high exactly when (pending AND enable) is non-zero. It reflects a register change in the cycle after the clock edge that made the change. A pending source whose enable bit is clear does not raise it.
- R7: A read at any offset other than 0x00 and 0x04 returns 0xFFFFFFFF. A write at such an offset changes neither register.
- R8: When a rising edge and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R9: Bits 31 to 11 of the pending and enable registers always read as zero, whatever data was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock internally |
| irq_line | input | 11 | Peripheral request lines, synchronous to clk |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Write strobe for the current offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, valid in the same cycle |
| cpu_irq | output | 1 | Level request to the CPU |

## Verification
The bench builds the block with its defaults: eleven sources, a 32-bit data path and an 8-bit offset. Because the offset is only eight bits wide, random addressing lands often on misaligned and unmapped offsets such as 0x01 or 0xFC, so the all-ones read and the ignored write get plenty of coverage. With eleven sources, writes with random data can clear some bits and keep others in a single access. Sparse random toggling of the lines then produces edges that coincide with acknowledges, as well as lines held high across an acknowledge.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int unsigned IRQ_SRC_N  = 11;
  localparam int unsigned IRQ_DATA_W = 32;
  localparam int unsigned IRQ_ADDR_W = 8;
  localparam int unsigned OFS_PEND   = 0;
  localparam int unsigned OFS_ENAB   = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PEND = 2'd1,
    SEL_ENAB = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned SRC_N = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] line,
  output logic [SRC_N-1:0] rise
);
  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    logic prev_q;
    logic prev_d;
    logic prev_en;

    always_comb begin
      prev_en = (line[g] != prev_q);
      prev_d  = line[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prev_q <= 1'b0;
      else if (prev_en) prev_q <= prev_d;
    end

    assign rise[g] = line[g] & ~prev_q;

    // R3: no rise is reported two cycles running on one source
    assert_no_double_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rise[g] |=> !rise[g]);
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned SRC_N  = 11,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  rise,
  input  logic              pend_we,
  input  logic              enab_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [SRC_N-1:0]  pend,
  output logic [SRC_N-1:0]  enab,
  output logic              req
);
  logic [SRC_N-1:0] pend_q, pend_d;
  logic [SRC_N-1:0] enab_q, enab_d;
  logic             pend_en, enab_en;
  logic [SRC_N-1:0] wbits;

  always_comb begin
    wbits   = wdata[SRC_N-1:0];
    pend_d  = pend_q;
    if (pend_we) pend_d = pend_q & wbits;
    pend_d  = pend_d | rise;
    pend_en = pend_we | (|rise);
    enab_d  = wbits;
    enab_en = enab_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      enab_q <= '0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (enab_en) enab_q <= enab_d;
    end
  end

  assign pend = pend_q;
  assign enab = enab_q;
  assign req  = |(pend_q & enab_q);

  // R2: every reported rise is visible as pending after the edge
  assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

  // R3: a pending bit appears only where a rise was reported
  assert_set_needs_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(rise)) == '0));

  // R4: without a rise, a clearing write leaves old AND data
  assert_ack_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_we && rise == '0) |=> (pend_q == ($past(pend_q) & $past(wdata[SRC_N-1:0]))));

  // R5: enable bits move only on an enable write
  assert_enab_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enab_we |=> $stable(enab_q));

  // R8: an edge beats a simultaneous clearing write
  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_we && (|rise)) |=> ((pend_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int unsigned SRC_N  = IRQ_SRC_N,
  parameter int unsigned DATA_W = IRQ_DATA_W,
  parameter int unsigned ADDR_W = IRQ_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  irq_line,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cpu_irq
);
  localparam int unsigned PAD_W = DATA_W - SRC_N;
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_ENAB = ADDR_W'(OFS_ENAB);

  logic             rst_s_n;
  logic [SRC_N-1:0] rise;
  logic [SRC_N-1:0] pend, enab;
  logic             req;
  reg_sel_e         sel;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_s_n)
  );

  irq_edge_detect #(.SRC_N(SRC_N)) u_edge (
    .clk  (clk),
    .rst_n(rst_s_n),
    .line (irq_line),
    .rise (rise)
  );

  always_comb begin
    if (reg_addr == A_PEND)      sel = SEL_PEND;
    else if (reg_addr == A_ENAB) sel = SEL_ENAB;
    else                         sel = SEL_NONE;
  end

  irq_pend_bank #(.SRC_N(SRC_N), .DATA_W(DATA_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .rise   (rise),
    .pend_we(reg_we && sel == SEL_PEND),
    .enab_we(reg_we && sel == SEL_ENAB),
    .wdata  (reg_wdata),
    .pend   (pend),
    .enab   (enab),
    .req    (req)
  );

  always_comb begin
    unique case (sel)
      SEL_PEND: reg_rdata = {{PAD_W{1'b0}}, pend};
      SEL_ENAB: reg_rdata = {{PAD_W{1'b0}}, enab};
      default:  reg_rdata = '1;
    endcase
  end

  assign cpu_irq = req;

  // R7: unmapped offsets read all ones
  assert_unmapped_ones_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reg_addr != A_PEND && reg_addr != A_ENAB) |-> (reg_rdata == '1));

  // R9: mapped registers never show bits above the sources
  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reg_addr == A_PEND || reg_addr == A_ENAB) |-> (reg_rdata[DATA_W-1:SRC_N] == '0));

  // R6: clearing every enable drops the request on the next cycle
  assert_all_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reg_we && reg_addr == A_ENAB && reg_wdata[SRC_N-1:0] == '0) |=> !cpu_irq);
endmodule

// File: tb/irq_latch_ctrl_bench.sv
module irq_latch_ctrl_bench;
  localparam int N = 11;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [N-1:0] irq_line;
  logic [7:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        cpu_irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [N-1:0] m_pend, m_enab, m_prev;
  logic [31:0]  last_rd;

  always #2.5 clk = ~clk;

  irq_latch_ctrl u_irq_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == 8'h00) return {21'd0, m_pend};
    if (a == 8'h04) return {21'd0, m_enab};
    return 32'hFFFF_FFFF;
  endfunction

  function automatic string read_tag(input logic [7:0] a);
    if (a == 8'h00) return "R4";
    if (a == 8'h04) return "R5";
    return "R7";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [N-1:0] ln, input logic [7:0] a,
                      input logic w, input logic [31:0] d);
    logic [N-1:0] rise;
    @(negedge clk);
    irq_line = ln; reg_addr = a; reg_we = w; reg_wdata = d;
    #1;
    last_rd = reg_rdata;
    check(read_tag(a), reg_rdata, exp_read(a));
    @(posedge clk);
    rise = ln & ~m_prev;
    if (w && a == 8'h00) m_pend = m_pend & d[N-1:0];
    m_pend = m_pend | rise;
    if (w && a == 8'h04) m_enab = d[N-1:0];
    m_prev = ln;
    #1;
    check("R6", {31'd0, cpu_irq}, {31'd0, |(m_pend & m_enab)});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] ln;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; irq_line = '0; reg_addr = 8'h00; reg_we = 1'b0; reg_wdata = '0;
    m_pend = '0; m_enab = '0; m_prev = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", reg_rdata, 32'h0);
    check("R1", {31'd0, cpu_irq}, 32'd0);
    reg_addr = 8'h04; #1;
    check("R1", reg_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R5 and R9: enable write drops bits above the sources
    step('0, 8'h04, 1'b1, 32'hFFFF_F008);
    step('0, 8'h04, 1'b0, '0);
    check("R9", last_rd, 32'h0000_0008);
    // R2: rising edge on source 3
    step(11'h008, 8'h00, 1'b0, '0);
    step(11'h008, 8'h00, 1'b0, '0);
    check("R2", last_rd, 32'h0000_0008);
    check("R6", {31'd0, cpu_irq}, 32'd1);
    // R4: acknowledge while line held high, R3: no re-trigger
    step(11'h008, 8'h00, 1'b1, ~32'h8);
    for (int i = 0; i < 3; i++) step(11'h008, 8'h00, 1'b0, '0);
    check("R3", last_rd, 32'h0);
    check("R3", {31'd0, cpu_irq}, 32'd0);
    step(11'h000, 8'h00, 1'b0, '0);
    step(11'h008, 8'h00, 1'b0, '0);
    step(11'h008, 8'h00, 1'b0, '0);
    check("R3", last_rd, 32'h0000_0008);
    // R6: masked source 5 does not raise request
    step(11'h008, 8'h00, 1'b1, 32'h0);
    step(11'h028, 8'h00, 1'b0, '0);
    step(11'h028, 8'h00, 1'b0, '0);
    check("R6", last_rd, 32'h0000_0020);
    check("R6", {31'd0, cpu_irq}, 32'd0);
    // R8: edge on source 3 with a clear-all write in the same cycle
    step(11'h020, 8'h00, 1'b0, '0);
    step(11'h028, 8'h00, 1'b1, 32'h0);
    step(11'h028, 8'h00, 1'b0, '0);
    check("R8", last_rd, 32'h0000_0008);
    // R7: unmapped reads and ignored writes
    step(11'h028, 8'h08, 1'b1, 32'h0);
    check("R7", last_rd, 32'hFFFF_FFFF);
    step(11'h028, 8'h01, 1'b1, 32'h0);
    step(11'h028, 8'hFC, 1'b1, 32'h0);
    step(11'h028, 8'h04, 1'b0, '0);
    check("R7", last_rd, 32'h0000_0008);

    // constrained random phase
    ln = 11'h028;
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      int sel;
      if ($urandom_range(0, 5) == 0) ln = ln ^ N'(1 << $urandom_range(0, N - 1));
      sel = $urandom_range(0, 9);
      a = (sel < 4) ? 8'h00 : (sel < 7) ? 8'h04 : (sel < 8) ? 8'h08 : 8'($urandom);
      step(ln, a, ($urandom_range(0, 3) == 0), $urandom);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule